// File: doc/BRIEF.md
# Locality Request-Grant Arbiter

This block decides which of five localities may use the trusted-module command path. Each locality reaches the block through its own 4 KB address window, selected by address bits [15:12]. Each window holds one byte-wide access register. A locality writes that register to ask for access, give access up, or forcibly take access. It reads the same register to see its grant state. The window of each access also tags the transaction with its source locality, so later logic knows who is talking.

Only one locality holds the grant at a time. A grant lasts until the holder gives it up. A request made while another locality holds the grant waits in a pending register. When the holder releases, the highest-numbered waiting locality receives the grant. A separate seize operation breaks a deadlock. It lets a strictly higher locality take the grant away, and it flags the locality that lost it. The current holder is driven out as the locality modifier for the downstream command logic.

Top module: `locality_arbiter`

## Requirements
- R1: Only window values 0 to 4 at offset 0x000 reach an access register. Writes elsewhere change no state. Reads elsewhere return 0x00.
- R2: When no locality holds the grant, a write with bit 1 (request) set grants the writer. From the next cycle, `loc_active_o` is 1 and `loc_mod_o` is the writer's number.
- R3: A request from a non-holder while the grant is held never changes the holder. The request is recorded as pending, and the requester's register then reads bit 1 as 1.
- R4: The holder releases by writing 1 to bit 5 or to bit 0. If nothing is pending, `loc_active_o` falls to 0 on the next cycle. The same write from a non-holder has no effect.
- R5: When the holder releases while requests are pending, the highest-numbered pending locality takes the grant on the next cycle, and its pending bit clears.
- R6: In the holder's register, bit 2 reads 1 exactly when some other locality has a pending request. Non-holders read bit 2 as 0.
- R7: A write with bit 3 (seize) set moves the grant to the writer only if a grant is held and the writer's number is strictly greater than the holder's. The displaced locality then reads bit 4 as 1. Any other seize has no effect. Within one write, a successful seize takes precedence over release and request; otherwise release is handled before request.
- R8: A locality clears its own bit 4 by writing 1 to bit 4.
- R9: Bit 7 of every access register reads 1. Bit 5 reads 1 only in the holder's register.
- R10: After reset, no locality holds the grant, and no request or seized flag is set. Every access register reads 0x80.
- R11: `src_hit_o` is 1 and `src_loc_o` is the window number while a valid access targets any address inside windows 0 to 4. `src_hit_o` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 16 | Byte address; bits [15:12] select the window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed access register |
| src_hit_o | output | 1 | Current access falls in a locality window |
| src_loc_o | output | 3 | Locality of the current access |
| loc_active_o | output | 1 | Some locality holds the grant |
| loc_mod_o | output | 3 | Locality holding the grant |

## Verification
The properties assume one register access per cycle at most, with the address and control stable across the clock edge. They also assume that `bus_write_i` is meaningful only when `bus_valid_i` is high. The bench drives each access for exactly one cycle, starting at a falling edge, and holds the bus idle in between. The bench keeps every write inside the intended window, except for the deliberate out-of-range and non-zero-offset cases. Those cases carry a valid address, so the decode assumptions still hold there.

// File: rtl/locality_arbiter_pkg.sv
`timescale 1ns/1ps
package locality_arbiter_pkg;
  // access register bit positions
  localparam int unsigned BIT_RELINQ      = 0;
  localparam int unsigned BIT_REQUEST     = 1;
  localparam int unsigned BIT_OTHERS_WAIT = 2;
  localparam int unsigned BIT_SEIZE       = 3;
  localparam int unsigned BIT_SEIZED      = 4;
  localparam int unsigned BIT_ACTIVE      = 5;
  localparam int unsigned BIT_VALID       = 7;
endpackage

// File: rtl/la_window_decode.sv
`timescale 1ns/1ps
module la_window_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LSB = 12,
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              src_hit_o,
  output logic              reg_hit_o,
  output logic [LOC_W-1:0]  loc_o,
  output logic [NUM_LOC-1:0] sel_o
);
  localparam int unsigned WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] win;
  logic             in_range;
  logic             off_zero;

  assign win       = addr_i[ADDR_W-1:WIN_LSB];
  assign in_range  = win < WIN_W'(NUM_LOC);
  assign off_zero  = addr_i[WIN_LSB-1:0] == '0;
  assign loc_o     = win[LOC_W-1:0];
  assign src_hit_o = valid_i && in_range;
  assign reg_hit_o = valid_i && in_range && off_zero;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_sel
    assign sel_o[g] = reg_hit_o && (loc_o == LOC_W'(g));
  end
endmodule

// File: rtl/la_prio_pick.sv
`timescale 1ns/1ps
module la_prio_pick #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // later (higher) index overrides lower
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/la_grant_state.sv
`timescale 1ns/1ps
module la_grant_state #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [LOC_W-1:0]   wr_loc_i,
  input  logic               op_req_i,
  input  logic               op_rel_i,
  input  logic               op_seize_i,
  input  logic               op_clr_seized_i,
  output logic               act_v_o,
  output logic [LOC_W-1:0]   act_loc_o,
  output logic [NUM_LOC-1:0] pend_o,
  output logic [NUM_LOC-1:0] seized_o
);
  logic               act_v_q, act_v_d;
  logic [LOC_W-1:0]   act_loc_q, act_loc_d;
  logic [NUM_LOC-1:0] pend_q, pend_d;
  logic [NUM_LOC-1:0] seized_q, seized_d;
  logic               pick_any;
  logic [LOC_W-1:0]   pick_idx;
  logic               is_holder;
  logic               seize_ok;

  la_prio_pick #(.N(NUM_LOC), .W(LOC_W)) u_pick (
    .req_i (pend_q),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  assign is_holder = act_v_q && (act_loc_q == wr_loc_i);
  assign seize_ok  = op_seize_i && act_v_q && (wr_loc_i > act_loc_q);

  always_comb begin
    act_v_d   = act_v_q;
    act_loc_d = act_loc_q;
    pend_d    = pend_q;
    seized_d  = seized_q;
    if (wr_en_i) begin
      if (seize_ok) begin
        act_loc_d           = wr_loc_i;
        seized_d[act_loc_q] = 1'b1;
        pend_d[wr_loc_i]    = 1'b0;
      end else if (op_rel_i && is_holder) begin
        if (pick_any) begin
          act_loc_d        = pick_idx;
          pend_d[pick_idx] = 1'b0;
        end else begin
          act_v_d = 1'b0;
        end
      end else if (op_req_i && !is_holder) begin
        if (!act_v_q) begin
          act_v_d          = 1'b1;
          act_loc_d        = wr_loc_i;
          pend_d[wr_loc_i] = 1'b0;
        end else begin
          pend_d[wr_loc_i] = 1'b1;
        end
      end
      if (op_clr_seized_i) seized_d[wr_loc_i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v_q   <= 1'b0;
      act_loc_q <= '0;
      pend_q    <= '0;
      seized_q  <= '0;
    end else begin
      act_v_q   <= act_v_d;
      act_loc_q <= act_loc_d;
      pend_q    <= pend_d;
      seized_q  <= seized_d;
    end
  end

  assign act_v_o   = act_v_q;
  assign act_loc_o = act_loc_q;
  assign pend_o    = pend_q;
  assign seized_o  = seized_q;
endmodule

// File: rtl/locality_arbiter.sv
`timescale 1ns/1ps
module locality_arbiter
  import locality_arbiter_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LSB = 12,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              src_hit_o,
  output logic [LOC_W-1:0]  src_loc_o,
  output logic              loc_active_o,
  output logic [LOC_W-1:0]  loc_mod_o
);
  logic               reg_hit;
  logic [LOC_W-1:0]   dec_loc;
  logic [NUM_LOC-1:0] dec_sel;
  logic               act_v;
  logic [LOC_W-1:0]   act_loc;
  logic [NUM_LOC-1:0] pend_q;
  logic [NUM_LOC-1:0] seized_q;
  logic               wr_en;
  logic               rd_en;
  logic               rd_holder;
  logic               unused_wdata;

  la_window_decode #(
    .ADDR_W (ADDR_W), .WIN_LSB (WIN_LSB), .NUM_LOC (NUM_LOC), .LOC_W (LOC_W)
  ) u_dec (
    .valid_i   (bus_valid_i),
    .addr_i    (bus_addr_i),
    .src_hit_o (src_hit_o),
    .reg_hit_o (reg_hit),
    .loc_o     (dec_loc),
    .sel_o     (dec_sel)
  );

  assign wr_en = reg_hit && bus_write_i;
  assign rd_en = reg_hit && !bus_write_i;

  la_grant_state #(.NUM_LOC (NUM_LOC), .LOC_W (LOC_W)) u_state (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en),
    .wr_loc_i        (dec_loc),
    .op_req_i        (bus_wdata_i[BIT_REQUEST]),
    .op_rel_i        (bus_wdata_i[BIT_ACTIVE] | bus_wdata_i[BIT_RELINQ]),
    .op_seize_i      (bus_wdata_i[BIT_SEIZE]),
    .op_clr_seized_i (bus_wdata_i[BIT_SEIZED]),
    .act_v_o         (act_v),
    .act_loc_o       (act_loc),
    .pend_o          (pend_q),
    .seized_o        (seized_q)
  );

  assign unused_wdata = ^{bus_wdata_i[BIT_OTHERS_WAIT], bus_wdata_i[6], bus_wdata_i[BIT_VALID]};

  assign rd_holder = act_v && (act_loc == dec_loc);

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      bus_rdata_o[BIT_VALID]       = 1'b1;
      bus_rdata_o[BIT_ACTIVE]      = rd_holder;
      bus_rdata_o[BIT_SEIZED]      = |(dec_sel & seized_q);
      bus_rdata_o[BIT_OTHERS_WAIT] = rd_holder && (|pend_q);
      bus_rdata_o[BIT_REQUEST]     = |(dec_sel & pend_q);
    end
  end

  assign src_loc_o    = dec_loc;
  assign loc_active_o = act_v;
  assign loc_mod_o    = act_loc;
endmodule

// File: rtl/la_checker.sv
`timescale 1ns/1ps
module la_checker
  import locality_arbiter_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LSB = 12,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LOC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_valid_i,
  input logic               bus_write_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               loc_active_o,
  input logic [LOC_W-1:0]   loc_mod_o,
  input logic [NUM_LOC-1:0] pend_i,
  input logic [NUM_LOC-1:0] seized_i
);
  localparam int unsigned WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] c_win;
  logic [LOC_W-1:0] c_loc;
  logic             c_reg;
  logic             c_wr;

  assign c_win = bus_addr_i[ADDR_W-1:WIN_LSB];
  assign c_loc = c_win[LOC_W-1:0];
  assign c_reg = bus_valid_i && (c_win < WIN_W'(NUM_LOC)) && (bus_addr_i[WIN_LSB-1:0] == '0);
  assign c_wr  = c_reg && bus_write_i;

  AST_PEND_NOT_HOLDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_active_o |-> !pend_i[loc_mod_o]); // R3

  AST_MISS_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_wr |=> $stable(loc_active_o) && $stable(loc_mod_o) && $stable(pend_i)); // R1

  AST_IDLE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && bus_wdata_i[BIT_REQUEST] && !loc_active_o)
      |=> loc_active_o && (loc_mod_o == $past(c_loc))); // R2

  AST_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && loc_active_o && !bus_wdata_i[BIT_SEIZE] && (c_loc != loc_mod_o))
      |=> loc_active_o && $stable(loc_mod_o)); // R3

  AST_SEIZE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && bus_wdata_i[BIT_SEIZE] && loc_active_o && (c_loc > loc_mod_o))
      |=> (loc_mod_o == $past(c_loc)) && seized_i[$past(loc_mod_o)]); // R7

  AST_VALID_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_reg && !bus_write_i) |-> bus_rdata_o[BIT_VALID]); // R9
endmodule

bind locality_arbiter la_checker #(
  .NUM_LOC (NUM_LOC), .ADDR_W (ADDR_W), .WIN_LSB (WIN_LSB), .DATA_W (DATA_W), .LOC_W (LOC_W)
) u_la_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .loc_active_o (loc_active_o),
  .loc_mod_o    (loc_mod_o),
  .pend_i       (pend_q),
  .seized_i     (seized_q)
);

// File: tb/locality_arbiter_tb_top.sv
`timescale 1ns/1ps
module locality_arbiter_tb_top;
  localparam logic [7:0] W_RELQ = 8'h01, W_REQ = 8'h02, W_SEIZE = 8'h08,
                         W_CLR = 8'h10, W_ACT = 8'h20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_valid_i = 1'b0;
  logic       bus_write_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       src_hit_o;
  logic [2:0] src_loc_o;
  logic       loc_active_o;
  logic [2:0] loc_mod_o;

  int total = 0;
  int failed = 0;

  always #10 clk_i = ~clk_i;

  locality_arbiter dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .bus_valid_i (bus_valid_i), .bus_write_i (bus_write_i),
    .bus_addr_i (bus_addr_i), .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o), .src_hit_o (src_hit_o), .src_loc_o (src_loc_o),
    .loc_active_o (loc_active_o), .loc_mod_o (loc_mod_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr_at(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic wr(input int l, input logic [7:0] d);
    wr_at({l[3:0], 12'h000}, d);
  endtask

  task automatic rd_at(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_valid_i = 1'b0;
  endtask

  task automatic rd(input int l, output logic [7:0] d);
    rd_at({l[3:0], 12'h000}, d);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R10 / R9 reset state
    chk("R10 active", loc_active_o, 0);
    for (int l = 0; l < 5; l++) begin
      rd(l, d);
      chk("R10 reg", d, 8'h80);
    end
    // R11 source tagging
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_addr_i = 16'h3010;
    #1 chk("R11 hit", src_hit_o, 1);
    chk("R11 loc", src_loc_o, 3);
    bus_addr_i = 16'h6000;
    #1 chk("R11 miss", src_hit_o, 0);
    bus_valid_i = 1'b0;
    // R1 ignored addresses
    wr_at(16'h0004, W_REQ);
    chk("R1 offset write", loc_active_o, 0);
    wr_at(16'h7000, W_REQ);
    chk("R1 window write", loc_active_o, 0);
    rd_at(16'h7000, d);
    chk("R1 window read", d, 0);
    rd_at(16'h1004, d);
    chk("R1 offset read", d, 0);
    // R2 idle grant
    wr(2, W_REQ);
    chk("R2 active", loc_active_o, 1);
    chk("R2 mod", loc_mod_o, 2);
    rd(2, d);
    chk("R9 holder", d, 8'hA0);
    // R3 pending
    wr(1, W_REQ);
    chk("R3 mod kept", loc_mod_o, 2);
    rd(1, d);
    chk("R3 pend bit", d, 8'h82);
    rd(2, d);
    chk("R6 holder sees wait", d, 8'hA4);
    // R4 non-holder release ignored
    wr(3, W_ACT);
    chk("R4 non-holder", loc_mod_o, 2);
    // R5 highest pending wins
    wr(4, W_REQ);
    wr(2, W_ACT);
    chk("R5 mod", loc_mod_o, 4);
    rd(4, d);
    chk("R5 reg", d, 8'hA4);
    // R4 relinquish bit
    wr(4, W_RELQ);
    chk("R4 relq pass", loc_mod_o, 1);
    wr(1, W_RELQ);
    chk("R4 release idle", loc_active_o, 0);
    // R7 seize without holder
    wr(3, W_SEIZE);
    chk("R7 no holder", loc_active_o, 0);
    // R7 / R8 seize sweep
    for (int h = 0; h < 5; h++) begin
      for (int r = 0; r < 5; r++) begin
        if (r != h) begin
          do_reset();
          wr(h, W_REQ);
          wr(r, W_SEIZE);
          chk("R7 seize mod", loc_mod_o, (r > h) ? r : h);
          rd(h, d);
          chk("R7 seized flag", d[4], (r > h) ? 1 : 0);
          if (r > h) begin
            wr(h, W_CLR);
            rd(h, d);
            chk("R8 clear", d, 8'h80);
          end
        end
      end
    end
    // R5 / R6 pending sweep, holder 0
    for (int m = 0; m < 16; m++) begin
      int win;
      do_reset();
      wr(0, W_REQ);
      win = 0;
      for (int b = 0; b < 4; b++) begin
        if (m[b]) begin
          wr(b + 1, W_REQ);
          win = b + 1;
        end
      end
      rd(0, d);
      chk("R6 wait bit", d[2], (m != 0) ? 1 : 0);
      wr(0, W_ACT);
      chk("R5 active", loc_active_o, (m != 0) ? 1 : 0);
      if (m != 0) chk("R5 winner", loc_mod_o, win);
    end
    finish_run();
  end
endmodule